// File: doc/BRIEF.md
# PWM Fault Input Conditioner

This block prepares one external fault or retrigger pin for use by a PWM output stage. The raw pin is first adjusted for polarity, so that a logic one always means "active". It then passes through a two-stage synchronizer and an optional noise filter. The filter accepts a new level only after the synchronized input has held it for four PWM clock cycles. It can be switched off to cut latency when the PWM clock runs from a prescaler.

A mode input selects how the conditioned signal is reported. In edge mode, each active edge produces a single-cycle event pulse for the PWM controller. In level mode, a registered level flag is raised for as long as the input sits at its active level. In level mode that flag also drives the force-inactive output, which gates the PWM pins.

A separate asynchronous path can also drive the force-inactive output. When it is enabled, the polarity-adjusted raw pin acts on that output directly, through combinational logic. This lets a fault shut the output stage down even while the PWM clock is stopped. The synchronous path keeps running beside it whenever the clock runs.

Top module: `pwm_fault_cond`

## Requirements
- R1: While rst_ni is low, level_o and event_o are 0. With async_en_i = 0, force_off_o is also 0. After release, with the pin inactive, no event fires and no level is reported.
- R2: With filt_en_i = 1, a new active state is accepted only after the synchronized input has held it for 4 consecutive clock cycles. level_o then changes on the 7th rising edge after the pin changes. A pin pulse lasting 3 cycles is ignored; one lasting 4 cycles is accepted.
- R3: With filt_en_i = 0, the filter is bypassed. level_o follows a pin change on the 3rd rising edge after it.
- R4: The pin is active high when act_low_i = 0 and active low when act_low_i = 1.
- R5: With edge_mode_i = 1, a change from inactive to active produces event_o = 1 for exactly one cycle, on the 3rd rising edge after the pin changes when unfiltered. A change from active to inactive produces no event. In this mode, level_o is 0 and the synchronous path does not drive force_off_o.
- R6: With edge_mode_i = 0, level_o and force_off_o are 1 while the conditioned input is active, and event_o stays 0.
- R7: With async_en_i = 1, the active pin level drives force_off_o to 1 at once, through combinational logic, with no clock edge needed. This also holds while the clock is stopped.
- R8: With async_en_i = 1, the synchronous path still runs: level_o rises and falls with the usual latency.
- R9: In level mode, a fault that has been registered keeps force_off_o at 1 while the clock is stopped, even after the pin returns to inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | PWM clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw fault or retrigger pin |
| filt_en_i | input | 1 | 1: enable the 4-cycle noise filter |
| act_low_i | input | 1 | 1: the pin is active low |
| edge_mode_i | input | 1 | 1: edge detection, 0: level detection |
| async_en_i | input | 1 | 1: enable the combinational shutdown path |
| event_o | output | 1 | Single-cycle pulse on an active edge (edge mode) |
| level_o | output | 1 | Registered active level (level mode) |
| force_off_o | output | 1 | Forces the PWM outputs inactive |

## Verification
The bench counts latency from the pin change. Level and event results are due on the 3rd rising edge when the filter is off and on the 7th when it is on. The asynchronous shutdown is due within the same cycle, with no edge needed. Inputs change on falling edges. Each check is made on the falling edge that follows the exact number of rising edges its latency calls for, so checks one edge early (for example, 6 edges with the filter on) confirm that the output has not yet moved. Filter boundaries are checked with pin pulses of 3 and 4 cycles. The asynchronous path and the held level fault are checked with the clock stopped, using short time delays instead of edges.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned FILT_CYCLES = 4;

  typedef enum logic {
    DET_LEVEL = 1'b0,
    DET_EDGE  = 1'b1
  } det_mode_e;
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= 1'b0;
        else         stage_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= 1'b0;
        else         stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pfc_filter.sv
module pfc_filter #(
  parameter int unsigned CYCLES = 4,
  localparam int unsigned CW = $clog2(CYCLES) + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  logic          acc_q;
  logic [CW-1:0] run_q;

  // run_q counts cycles the input has differed from the accepted level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      run_q <= '0;
    end else if (in_i == acc_q) begin
      run_q <= '0;
    end else if (run_q == CW'(CYCLES - 1)) begin
      acc_q <= in_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign out_o = acc_q;

  AST_FILT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q != $past(acc_q)) |-> ($past(in_i) == acc_q)) // R2
    else $error("accepted level differs from sampled input");

  AST_FILT_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < CW'(CYCLES)) // R2
    else $error("filter run counter out of range");
endmodule

// File: rtl/pfc_detect.sv
module pfc_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic edge_mode_i,
  output logic event_o,
  output logic level_o
);
  import pwm_fault_pkg::*;

  logic      lvl_q;
  logic      evt_q;
  det_mode_e mode;

  assign mode = det_mode_e'(edge_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      lvl_q <= act_i;
      evt_q <= (mode == DET_EDGE) && act_i && !lvl_q;
    end
  end

  assign event_o = evt_q;
  assign level_o = (mode == DET_LEVEL) && lvl_q;

  AST_EVENT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q) // R5
    else $error("event longer than one cycle");

  AST_EVENT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> (lvl_q && !$past(lvl_q))) // R5
    else $error("event without rising conditioned level");
endmodule

// File: rtl/pwm_fault_cond.sv
module pwm_fault_cond #(
  parameter int unsigned SYNC_STAGES = pwm_fault_pkg::SYNC_STAGES,
  parameter int unsigned FILT_CYCLES = pwm_fault_pkg::FILT_CYCLES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic filt_en_i,
  input  logic act_low_i,
  input  logic edge_mode_i,
  input  logic async_en_i,
  output logic event_o,
  output logic level_o,
  output logic force_off_o
);
  logic act_raw;
  logic act_sync;
  logic act_filt;
  logic act_sel;
  logic det_level;

  assign act_raw = pin_i ^ act_low_i;

  pfc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (act_raw),
    .q_o    (act_sync)
  );

  pfc_filter #(.CYCLES(FILT_CYCLES)) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (act_sync),
    .out_o  (act_filt)
  );

  assign act_sel = filt_en_i ? act_filt : act_sync;

  pfc_detect u_detect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act_sel),
    .edge_mode_i (edge_mode_i),
    .event_o     (event_o),
    .level_o     (det_level)
  );

  assign level_o     = det_level;
  // async leg is purely combinational so it works with the clock stopped
  assign force_off_o = det_level | (async_en_i & act_raw);

  AST_LEVEL_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o |-> force_off_o) // R6
    else $error("level fault not forcing outputs off");

  AST_NO_EVENT_LEVEL_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $past(edge_mode_i)) // R5
    else $error("event raised in level mode");

  AST_EDGE_NO_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_mode_i |-> !level_o) // R5
    else $error("level reported in edge mode");

  always_comb begin
    if (async_en_i && act_raw)
      AST_ASYNC_FORCE: assert (force_off_o) // R7
        else $error("async shutdown not effective");
  end
endmodule

// File: tb/pwm_fault_cond_bench.sv
`timescale 1ns/1ps
module pwm_fault_cond_bench;
  logic clk = 1'b0;
  logic clk_run = 1'b1;
  logic rst_n;
  logic pin, filt_en, act_low, edge_mode, async_en;
  logic event_w, level_w, force_w;
  int   n_chk = 0;
  int   n_bad = 0;

  always #2.5 if (clk_run) clk = ~clk;

  pwm_fault_cond u_pwm_fault_cond (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pin),
    .filt_en_i   (filt_en),
    .act_low_i   (act_low),
    .edge_mode_i (edge_mode),
    .async_en_i  (async_en),
    .event_o     (event_w),
    .level_o     (level_w),
    .force_off_o (force_w)
  );

  typedef struct packed {
    logic       f;
    logic       p;
    logic       e;
    logic       a;
    logic       r;
    logic [3:0] hold;
    logic       lvl;
    logic       frc;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'd3,1'b1,1'b1}, // R3 R6 unfiltered rise
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd3,1'b0,1'b0}, // R3 unfiltered fall
    '{1'b1,1'b0,1'b0,1'b0,1'b1,4'd6,1'b0,1'b0}, // R2 one edge early
    '{1'b1,1'b0,1'b0,1'b0,1'b1,4'd1,1'b1,1'b1}, // R2 7th edge
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'd6,1'b1,1'b1}, // R2 release early
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'd1,1'b0,1'b0}, // R2 release
    '{1'b0,1'b1,1'b0,1'b0,1'b1,4'd3,1'b0,1'b0}, // R4 high is inactive
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'd3,1'b1,1'b1}, // R4 low is active
    '{1'b0,1'b1,1'b0,1'b0,1'b1,4'd3,1'b0,1'b0}, // R4
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd3,1'b0,1'b0}, // R5 no level/force in edge mode
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'd1,1'b1,1'b1}, // R6 back to level mode
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd3,1'b0,1'b0}, // R7 idle
    '{1'b1,1'b0,1'b0,1'b1,1'b1,4'd0,1'b0,1'b1}, // R7 immediate force
    '{1'b1,1'b0,1'b0,1'b1,1'b1,4'd7,1'b1,1'b1}, // R8 sync level follows
    '{1'b1,1'b0,1'b0,1'b1,1'b0,4'd0,1'b1,1'b1}, // R8 held by sync path
    '{1'b1,1'b0,1'b0,1'b1,1'b0,4'd7,1'b0,1'b0}, // R8 released
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd3,1'b0,1'b0}  // R3 settle
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pin = 1'b0; filt_en = 1'b0; act_low = 1'b0;
    edge_mode = 1'b0; async_en = 1'b0;
    negs(3);
    chk("R1 level in reset", level_w, 1'b0);
    chk("R1 event in reset", event_w, 1'b0);
    chk("R1 force in reset", force_w, 1'b0);
    rst_n = 1'b1;
    negs(8);
    chk("R1 level after reset", level_w, 1'b0);
    chk("R1 force after reset", force_w, 1'b0);

    for (int i = 0; i < NV; i++) begin
      filt_en = VEC[i].f; act_low = VEC[i].p; edge_mode = VEC[i].e;
      async_en = VEC[i].a; pin = VEC[i].r;
      if (VEC[i].hold == 0) #1;
      else negs(int'(VEC[i].hold));
      chk($sformatf("vector %0d level", i), level_w, VEC[i].lvl);
      chk($sformatf("vector %0d force", i), force_w, VEC[i].frc);
    end

    // R2 glitch of 3 cycles is rejected
    filt_en = 1'b1; edge_mode = 1'b0; async_en = 1'b0; act_low = 1'b0;
    pin = 1'b1; negs(3); pin = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R2 3-cycle glitch", level_w, 1'b0);
    end
    // R2 pulse of 4 cycles is accepted on the 7th edge
    pin = 1'b1; negs(4); pin = 1'b0;
    negs(2);
    chk("R2 4-cycle pulse early", level_w, 1'b0);
    negs(1);
    chk("R2 4-cycle pulse accepted", level_w, 1'b1);
    negs(12);
    chk("R2 4-cycle pulse released", level_w, 1'b0);

    // R5 edge event timing
    filt_en = 1'b0; edge_mode = 1'b1; pin = 1'b0; negs(4);
    pin = 1'b1;
    negs(2); chk("R5 event early", event_w, 1'b0);
    negs(1); chk("R5 event pulse", event_w, 1'b1);
    negs(1); chk("R5 event single cycle", event_w, 1'b0);
    pin = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R5 no event on inactive edge", event_w, 1'b0);
    end
    // R6 no event in level mode
    edge_mode = 1'b0; pin = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R6 no event in level mode", event_w, 1'b0);
    end
    pin = 1'b0; negs(4);

    // R7 async shutdown with the clock stopped
    async_en = 1'b1; negs(1);
    clk_run = 1'b0; #20;
    pin = 1'b1; #3;
    chk("R7 async force clock stopped", force_w, 1'b1);
    pin = 1'b0; #3;
    chk("R7 async release clock stopped", force_w, 1'b0);
    clk_run = 1'b1;
    negs(4);

    // R9 registered level fault holds while the clock is stopped
    async_en = 1'b0; filt_en = 1'b1; pin = 1'b1;
    negs(8);
    chk("R9 level fault registered", force_w, 1'b1);
    clk_run = 1'b0; #20;
    pin = 1'b0; #20;
    chk("R9 force held clock stopped", force_w, 1'b1);
    chk("R9 level held clock stopped", level_w, 1'b1);
    clk_run = 1'b1;
    negs(12);
    chk("R9 release after clock resumes", force_w, 1'b0);

    finish_run();
  end
endmodule